// File: doc/BRIEF.md
# Programmable Line Pulse Shape Sequencer

This block produces the digital amplitude code for one transmit channel of a T1/E1 line driver. It runs on an oversampling clock that gives 32 ticks per bit period. A one-cycle bit strobe opens each period and carries the data bit. A zero bit yields a flat zero code. A mark yields a shaped pulse built from consecutive sections: overshoot, plateau and up to three undershoot levels. Successive marks take alternating polarity. The signed code on `level_o` drives a DAC, one value per tick.

Every section level can be trimmed by a sign-magnitude step count. Every boundary between sections can be shifted by up to three ticks in either direction. A 4-bit gain code scales the whole waveform, and the trims scale with it. In T1 mode all five sections are produced. In E1 mode only the overshoot and the plateau are produced, and the line returns to zero after the second boundary. Nominal section levels and nominal boundary ticks are parameters. All configuration is captured on the bit strobe, so a pulse already in progress is never altered.

Top module: `lps_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first strobe, `level_o` is 0. The first mark after reset has positive polarity.
- R2: A strobe with `bit_i`=0 gives `level_o`=0 for all 32 ticks of that period. If no strobe follows tick 31, `level_o` returns to 0 one cycle after tick 31 is shown.
- R3: Each mark flips polarity relative to the previous mark, and zero bits do not change the polarity. A negative mark shows the exact two's-complement negation of the positive code.
- R4: A strobe is sampled at clock edge E0. The code for tick t (0..31) is on `level_o` from edge E(t+1). In T1 mode, with boundary ticks b0<=b1<=b2<=b3, tick t belongs to section s, where s is the number of boundaries with b_k <= t. The sections are 0 overshoot, 1 plateau, 2..4 undershoots.
- R5: Boundary k is EDGE_NOM[k] plus the signed value of its 3-bit field `edge_trim_i[3k+2:3k]`. Bit 2 is the sign (1 = earlier) and bits 1:0 give the tick count.
- R6: An adjusted boundary is clamped to at most 31. It is then raised to at least the previous clamped boundary, with 0 used in place of a previous boundary for b0.
- R7: The trim for section s (0..3) is `lvl_trim_i[5s+4:5s]`, with bit 4 as sign and bits 3:0 as magnitude (range ±15). The trim for section 4 is `tail_trim_i`, with bit 3 as sign and bits 2:0 as magnitude (range ±7). For example, 4'b1011 means −3.
- R8: Section code = floor(((LVL_NOM[s] + trim) * G + 512) / 1024). G by gain code 0..15 is 1024, 1051, 1078, 1106, 1138, 1169, 1205, 1242, 1001, 974, 951, 933, 910, 901, 869, 856.
- R9: In E1 mode (`e1_mode_i`=1), only b0 and b1 are applied. The code is 0 from tick b1 to the end of the period. Trims of sections 2..4 and of b2 and b3 have no effect.
- R10: Mode, trims, gain and bit are taken only at the strobe. Changes between strobes do not affect the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 32 ticks per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_stb_i | input | 1 | One-cycle strobe opening a bit period |
| bit_i | input | 1 | Data bit, 1 = mark |
| e1_mode_i | input | 1 | 1 = E1 two-section pulse, 0 = T1 five-section pulse |
| lvl_trim_i | input | (NSEC-1)*5 | Level trims, sections 0..3 |
| tail_trim_i | input | 4 | Level trim, last undershoot |
| edge_trim_i | input | (NSEC-1)*3 | Boundary trims, boundaries 0..3 |
| gain_i | input | 4 | Global gain code |
| level_o | output | OUT_W | Signed DAC code |

## Verification
The bench builds the block with nominal boundaries at ticks 1, 5, 6 and 30, and keeps the default nominal levels. With a ±3-tick trim, these boundaries can reach the low limit at tick 0, the upper limit at tick 31, and the ordering clamp where a late plateau end overtakes an early third boundary. With this setting every clamp branch is reachable. Every level trim code, every boundary trim code and every gain code is swept over full periods in T1 mode. E1 periods with random undershoot trims show that those trims are ignored. Further periods change the inputs partway through to show that configuration is captured only at the strobe.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int GAIN_FRAC = 10;
  localparam int GAIN_HALF = 1 << (GAIN_FRAC - 1);

  // sign-magnitude field of width w -> signed int
  function automatic int sm_decode(input int code, input int w);
    int mag;
    mag = code & ((1 << (w - 1)) - 1);
    if (((code >> (w - 1)) & 1) != 0) return -mag;
    return mag;
  endfunction

  // gain coefficient, Q.GAIN_FRAC
  function automatic int gain_coef(input logic [3:0] code);
    case (code)
      4'd0:  return 1024;
      4'd1:  return 1051;
      4'd2:  return 1078;
      4'd3:  return 1106;
      4'd4:  return 1138;
      4'd5:  return 1169;
      4'd6:  return 1205;
      4'd7:  return 1242;
      4'd8:  return 1001;
      4'd9:  return 974;
      4'd10: return 951;
      4'd11: return 933;
      4'd12: return 910;
      4'd13: return 901;
      4'd14: return 869;
      default: return 856;
    endcase
  endfunction
endpackage

// File: rtl/lps_bit_timer.sv
module lps_bit_timer #(
  parameter int TICKS  = 32,
  parameter int TICK_W = $clog2(TICKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bit_i,
  input  logic              mode_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              run_o,
  output logic              mark_o,
  output logic              neg_o,
  output logic              e1_o
);
  logic neg_next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o     <= '0;
      run_o      <= 1'b0;
      mark_o     <= 1'b0;
      neg_o      <= 1'b0;
      e1_o       <= 1'b0;
      neg_next_q <= 1'b0;
    end else if (stb_i) begin
      tick_o <= '0;
      run_o  <= 1'b1;
      mark_o <= bit_i;
      e1_o   <= mode_i;
      if (bit_i) begin
        neg_o      <= neg_next_q;
        neg_next_q <= ~neg_next_q;
      end
    end else if (run_o) begin
      if (tick_o == TICK_W'(TICKS - 1)) run_o <= 1'b0;
      else tick_o <= tick_o + 1'b1;
    end
  end
endmodule

// File: rtl/lps_edge_map.sv
module lps_edge_map
  import lps_pkg::*;
#(
  parameter int TICKS  = 32,
  parameter int NEDGE  = 4,
  parameter int TRIM_W = 3,
  parameter int EDGE_NOM [NEDGE] = '{4, 16, 22, 27},
  parameter int TICK_W = $clog2(TICKS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NEDGE*TRIM_W-1:0]      trim_i,
  output logic [NEDGE-1:0][TICK_W-1:0] edge_o
);
  logic [NEDGE-1:0][TICK_W-1:0] edge_d;

  always_comb begin
    int prev;
    int raw;
    prev = 0;
    for (int k = 0; k < NEDGE; k++) begin
      raw = EDGE_NOM[k] + sm_decode(32'(trim_i[k*TRIM_W +: TRIM_W]), TRIM_W);
      if (raw > TICKS - 1) raw = TICKS - 1;
      if (raw < prev) raw = prev;  // keeps order, also floors at 0
      edge_d[k] = TICK_W'(raw);
      prev = raw;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_o <= '0;
    else if (load_i) edge_o <= edge_d;
  end
endmodule

// File: rtl/lps_level_map.sv
module lps_level_map
  import lps_pkg::*;
#(
  parameter int NSEC   = 5,
  parameter int TRIM_W = 5,
  parameter int TAIL_W = 4,
  parameter int OUT_W  = 10,
  parameter int LVL_NOM [NSEC] = '{96, 72, -24, -16, -8}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [(NSEC-1)*TRIM_W-1:0]    trim_i,
  input  logic [TAIL_W-1:0]             tail_i,
  input  logic [3:0]                    gain_i,
  output logic [NSEC-1:0][OUT_W-1:0]    lvl_o
);
  int gain;
  assign gain = gain_coef(gain_i);

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    int trim;
    int prod;
    int rnd;
    if (k == NSEC - 1) begin : g_tail
      assign trim = sm_decode(32'(tail_i), TAIL_W);
    end else begin : g_body
      assign trim = sm_decode(32'(trim_i[k*TRIM_W +: TRIM_W]), TRIM_W);
    end
    // trim added before scaling: step size tracks gain
    assign prod = (LVL_NOM[k] + trim) * gain;
    assign rnd  = (prod + GAIN_HALF) >>> GAIN_FRAC;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_o[k] <= '0;
      else if (load_i) lvl_o[k] <= OUT_W'(rnd);
    end
  end
endmodule

// File: rtl/lps_top.sv
module lps_top #(
  parameter int TICKS       = 32,
  parameter int NSEC        = 5,
  parameter int E1_SEC      = 2,
  parameter int OUT_W       = 10,
  parameter int LVL_TRIM_W  = 5,
  parameter int TAIL_TRIM_W = 4,
  parameter int EDGE_TRIM_W = 3,
  parameter int LVL_NOM  [NSEC]   = '{96, 72, -24, -16, -8},
  parameter int EDGE_NOM [NSEC-1] = '{4, 16, 22, 27},
  localparam int NEDGE  = NSEC - 1,
  localparam int TICK_W = $clog2(TICKS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bit_stb_i,
  input  logic                          bit_i,
  input  logic                          e1_mode_i,
  input  logic [NEDGE*LVL_TRIM_W-1:0]   lvl_trim_i,
  input  logic [TAIL_TRIM_W-1:0]        tail_trim_i,
  input  logic [NEDGE*EDGE_TRIM_W-1:0]  edge_trim_i,
  input  logic [3:0]                    gain_i,
  output logic signed [OUT_W-1:0]       level_o
);
  logic [TICK_W-1:0]            tick_q;
  logic                         run_q, mark_q, neg_q, e1_q;
  logic [NEDGE-1:0][TICK_W-1:0] edge_q;
  logic [NSEC-1:0][OUT_W-1:0]   lvl_q;
  logic [OUT_W-1:0]             sel, lvl_d;

  lps_bit_timer #(.TICKS(TICKS), .TICK_W(TICK_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (bit_stb_i),
    .bit_i  (bit_i),
    .mode_i (e1_mode_i),
    .tick_o (tick_q),
    .run_o  (run_q),
    .mark_o (mark_q),
    .neg_o  (neg_q),
    .e1_o   (e1_q)
  );

  lps_edge_map #(
    .TICKS(TICKS), .NEDGE(NEDGE), .TRIM_W(EDGE_TRIM_W),
    .EDGE_NOM(EDGE_NOM), .TICK_W(TICK_W)
  ) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bit_stb_i),
    .trim_i (edge_trim_i),
    .edge_o (edge_q)
  );

  lps_level_map #(
    .NSEC(NSEC), .TRIM_W(LVL_TRIM_W), .TAIL_W(TAIL_TRIM_W),
    .OUT_W(OUT_W), .LVL_NOM(LVL_NOM)
  ) u_levels (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bit_stb_i),
    .trim_i (lvl_trim_i),
    .tail_i (tail_trim_i),
    .gain_i (gain_i),
    .lvl_o  (lvl_q)
  );

  always_comb begin
    int n_edge;
    int n_sec;
    int sec;
    n_edge = e1_q ? E1_SEC : NEDGE;
    n_sec  = e1_q ? E1_SEC : NSEC;
    sec    = 0;
    for (int k = 0; k < NEDGE; k++)
      if (k < n_edge && tick_q >= edge_q[k]) sec++;
    sel = '0;
    for (int k = 0; k < NSEC; k++)
      if (k == sec) sel = lvl_q[k];
    if (!run_q || !mark_q || sec >= n_sec) lvl_d = '0;
    else lvl_d = neg_q ? -sel : sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else level_o <= lvl_d;
  end
endmodule

// File: rtl/lps_chk.sv
module lps_chk #(
  parameter int TICK_W = 5,
  parameter int NEDGE  = 4,
  parameter int NSEC   = 5,
  parameter int OUT_W  = 10,
  parameter int E1_SEC = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         bit_stb_i,
  input logic                         bit_i,
  input logic signed [OUT_W-1:0]      level_o,
  input logic [TICK_W-1:0]            tick_q,
  input logic                         run_q,
  input logic                         e1_q,
  input logic [NEDGE-1:0][TICK_W-1:0] edge_q,
  input logic [NSEC-1:0][OUT_W-1:0]   lvl_q
);
  logic space_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) space_q <= 1'b0;
    else if (bit_stb_i) space_q <= !bit_i;
  end

  AST_SPACE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    space_q |=> level_o == '0);  // R2

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> level_o == '0);  // R2

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(edge_q) && $stable(lvl_q));  // R10

  AST_E1_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && e1_q && tick_q >= edge_q[E1_SEC-1] |=> level_o == '0);  // R9

  for (genvar k = 1; k < NEDGE; k++) begin : g_ord
    AST_EDGE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_q[k] >= edge_q[k-1]);  // R6
  end
endmodule

bind lps_top lps_chk #(
  .TICK_W(TICK_W), .NEDGE(NEDGE), .NSEC(NSEC), .OUT_W(OUT_W), .E1_SEC(E1_SEC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_stb_i (bit_stb_i),
  .bit_i     (bit_i),
  .level_o   (level_o),
  .tick_q    (tick_q),
  .run_q     (run_q),
  .e1_q      (e1_q),
  .edge_q    (edge_q),
  .lvl_q     (lvl_q)
);

// File: tb/sim_lps_top.sv
`timescale 1ns/1ps
module sim_lps_top;
  localparam int TICKS = 32;
  localparam int LN [5] = '{96, 72, -24, -16, -8};
  localparam int EN [4] = '{1, 5, 6, 30};
  localparam int GQ [16] = '{1024, 1051, 1078, 1106, 1138, 1169, 1205, 1242,
                             1001, 974, 951, 933, 910, 901, 869, 856};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_stb = 1'b0, bit_v = 1'b0, e1 = 1'b0;
  logic [19:0] lvl_trim = '0;
  logic [3:0]  tail_trim = '0;
  logic [11:0] edge_trim = '0;
  logic [3:0]  gain = '0;
  logic signed [9:0] level;

  always #4 clk = ~clk;

  lps_top #(.LVL_NOM(LN), .EDGE_NOM(EN)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb),
    .bit_i       (bit_v),
    .e1_mode_i   (e1),
    .lvl_trim_i  (lvl_trim),
    .tail_trim_i (tail_trim),
    .edge_trim_i (edge_trim),
    .gain_i      (gain),
    .level_o     (level)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // period captured at strobe
  bit          p_bit, p_e1, p_neg, neg_next;
  logic [19:0] p_lvl;
  logic [3:0]  p_tail, p_gain;
  logic [11:0] p_edge;
  bit          pend_valid = 1'b0;
  int          pend_exp;
  string       pend_tag;

  function automatic int sm(int code, int w);
    int mag;
    mag = code & ((1 << (w - 1)) - 1);
    return ((code >> (w - 1)) & 1) != 0 ? -mag : mag;
  endfunction

  function automatic int exp_at(int t);
    int e [4];
    int prev, raw, sec, ne, ns, trim, v;
    prev = 0;
    for (int k = 0; k < 4; k++) begin
      raw = EN[k] + sm(int'((p_edge >> (3 * k)) & 12'h7), 3);
      if (raw > 31) raw = 31;
      if (raw < prev) raw = prev;
      e[k] = raw;
      prev = raw;
    end
    ne = p_e1 ? 2 : 4;
    ns = p_e1 ? 2 : 5;
    sec = 0;
    for (int k = 0; k < ne; k++) if (t >= e[k]) sec++;
    if (!p_bit || sec >= ns) return 0;
    trim = (sec < 4) ? sm(int'((p_lvl >> (5 * sec)) & 20'h1f), 5) : sm(int'(p_tail), 4);
    v = ((LN[sec] + trim) * GQ[p_gain] + 512) >>> 10;
    return p_neg ? -v : v;
  endfunction

  task automatic check(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: level got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // called at a negedge; drives one full bit period and checks each tick
  task automatic run_period(bit b, bit scramble, string tag);
    bit_stb = 1'b1;
    bit_v   = b;
    p_bit = b; p_e1 = e1; p_lvl = lvl_trim; p_tail = tail_trim;
    p_edge = edge_trim; p_gain = gain;
    if (b) begin
      p_neg    = neg_next;
      neg_next = !neg_next;
    end
    for (int t = 0; t < TICKS; t++) begin
      @(negedge clk);
      if (t == 0) begin
        bit_stb = 1'b0;
        if (pend_valid) check(int'(level), pend_exp, pend_tag);
      end else begin
        check(int'(level), exp_at(t - 1), tag);
      end
      if (scramble && t == 10) begin
        lvl_trim  = 20'($urandom);
        tail_trim = 4'($urandom);
        edge_trim = 12'($urandom);
        gain      = 4'($urandom);
        e1        = ~e1;
        bit_v     = ~bit_v;
      end
    end
    pend_valid = 1'b1;
    pend_exp   = exp_at(TICKS - 1);
    pend_tag   = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0 && pend_valid) check(int'(level), pend_exp, pend_tag);
      else check(int'(level), 0, "R2 idle");
    end
    pend_valid = 1'b0;
  endtask

  task automatic zero_cfg();
    lvl_trim = '0; tail_trim = '0; edge_trim = '0; gain = '0; e1 = 1'b0;
  endtask

  initial begin
    neg_next = 1'b0;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    check(int'(level), 0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check(int'(level), 0, "R1 after reset");

    // first mark positive, nominal T1 shape
    run_period(1'b1, 1'b0, "R1");
    run_period(1'b1, 1'b0, "R4");
    run_period(1'b1, 1'b0, "R4");

    // polarity pattern with spaces
    run_period(1'b0, 1'b0, "R2");
    run_period(1'b1, 1'b0, "R3");
    run_period(1'b0, 1'b0, "R2");
    run_period(1'b0, 1'b0, "R2");
    run_period(1'b1, 1'b0, "R3");
    run_period(1'b1, 1'b0, "R3");

    // gain sweep
    for (int g = 0; g < 16; g++) begin
      gain = 4'(g);
      run_period(1'b1, 1'b0, "R8");
      run_period(1'b1, 1'b0, "R8");
    end
    zero_cfg();

    // level trims, every code per section
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) begin
        lvl_trim = 20'(c) << (5 * s);
        gain = 4'(c % 16);
        run_period(1'b1, 1'b0, "R7");
      end
    lvl_trim = '0;
    for (int c = 0; c < 16; c++) begin
      tail_trim = 4'(c);
      run_period(1'b1, 1'b0, "R7");
    end
    zero_cfg();

    // edge trims, every code per boundary
    for (int e = 0; e < 4; e++)
      for (int c = 0; c < 8; c++) begin
        edge_trim = 12'(c) << (3 * e);
        run_period(1'b1, 1'b0, "R5");
      end

    // clamp corners: b0 early, b1 late, b2 early, b3 late
    edge_trim = 12'(7 | (3 << 3) | (7 << 6) | (3 << 9));
    run_period(1'b1, 1'b0, "R6");
    run_period(1'b1, 1'b0, "R6");
    for (int i = 0; i < 32; i++) begin
      edge_trim = 12'($urandom);
      lvl_trim  = 20'($urandom);
      tail_trim = 4'($urandom);
      run_period(1'b1, 1'b0, "R6");
    end
    zero_cfg();

    // E1: undershoot trims and late boundaries are irrelevant
    e1 = 1'b1;
    for (int i = 0; i < 40; i++) begin
      lvl_trim  = 20'($urandom);
      tail_trim = 4'($urandom);
      edge_trim = 12'($urandom);
      gain      = 4'($urandom);
      run_period((i % 5) != 4, 1'b0, "R9");
    end
    zero_cfg();

    // inputs changed partway through a period
    for (int i = 0; i < 24; i++) begin
      lvl_trim  = 20'($urandom);
      tail_trim = 4'($urandom);
      edge_trim = 12'($urandom);
      gain      = 4'($urandom);
      e1        = 1'($urandom);
      run_period((i % 4) != 3, 1'b1, "R10");
    end

    idle(40);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog: got no finish expected finish");
      summary();
      $finish;
    end
  end
endmodule